// File: doc/BRIEF.md
# Retention Register with Sequence Monitor

This block models a WIDTH-bit state-retaining register for low-power designs, together with a checker for its control sequence. A fast monitor clock `clk` samples every input. The register clock `rclk_i`, the retention control `keep_i` and the supply status inputs are treated as slow signals. An edge on one of them is a change in its value between two consecutive samples of `clk`.

While the primary supply is good and `keep_i` is high, the main register loads `din_i` on each rising edge of `rclk_i`. A backup copy stays on the always-on domain and follows the main register for as long as `keep_i` is high. A falling edge of `keep_i` reloads the main register from the backup copy. This is how the value comes back after primary power has been removed and restored. While `keep_i` is low, register clock edges are ignored.

The monitor keeps three sticky error flags: an unsafe power-down, a restore made while `rclk_i` was high, and backup loss during power-down. It also stores the value of a free-running cycle counter at the first error since reset or since the last clear. The output carries a valid flag. Whenever the flag is low the data bits are driven unknown.

Top module: `retention_reg`

## Requirements
- R1: A rising edge of `rclk_i` seen while `prim_ok_i` and `keep_i` are high loads `din_i` into the main register; `dout_o` shows it after that `clk` edge.
- R2: Edges of `rclk_i` seen while `keep_i` is low do not change the stored value.
- R3: The backup copy follows the main register while `keep_i`, `prim_ok_i` and `bkup_ok_i` are high and the main register holds a value. A falling edge of `keep_i` with `rclk_i` low reloads the main register from it, which also holds after a primary power cycle.
- R4: A falling edge of `keep_i` while `rclk_i` is high sets `err_restore_o` and leaves the main register without a valid value.
- R5: `dout_valid_o` is high only while `prim_ok_i`, `bkup_ok_i` and `gnd_ok_i` are all high and the main register holds a value; otherwise `dout_o` is driven unknown.
- R6: `prim_ok_i` going low while `keep_i` was high in the previous sample sets `err_save_o`.
- R7: `bkup_ok_i` low while `prim_ok_i` is low sets `err_lost_o`. Backup loss at any time discards the backup copy, so a later restore gives an invalid output.
- R8: After `prim_ok_i` returns, the main register has no valid value until a capture (R1) or a restore (R3).
- R9: Each error flag stays set until `clr_i` is high at a `clk` edge. A clear and a new error in the same cycle leave the new error set.
- R10: `stamp_o` takes the cycle count (0 at the first `clk` edge after reset) of the first error since reset or clear, and later errors do not change it.
- R11: A synchronous active-low `rst_n` empties both copies and clears the flags, the stamp and the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor/sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rclk_i | input | 1 | Register clock (sampled) |
| din_i | input | WIDTH | Data to capture |
| keep_i | input | 1 | Retention control: high runs and saves, falling edge restores |
| prim_ok_i | input | 1 | Primary supply good |
| bkup_ok_i | input | 1 | Always-on backup supply good |
| gnd_ok_i | input | 1 | Ground and bias status good |
| clr_i | input | 1 | Clears the error flags |
| dout_o | output | WIDTH | Register output, unknown when not valid |
| dout_valid_o | output | 1 | Output holds a real value |
| err_save_o | output | 1 | Primary dropped while saving |
| err_restore_o | output | 1 | Restore made with register clock high |
| err_lost_o | output | 1 | Backup lost during power-down |
| stamp_o | output | CNT_W | Cycle count at the first error |

## Verification
A wrong main-register value shows on `dout_o` at the first sample after the capturing `clk` edge. A corrupt or stale backup copy stays hidden until the next falling edge of `keep_i`. The bench therefore restores after each power cycle and after each backup loss, and checks the restored word or the valid flag at that point. Flag and stamp faults appear one `clk` edge after the triggering sample. The bench keeps its own count of edges since reset to predict the stamp, and issues a second error while the first is still set to show that the stamp is held.

// File: rtl/retreg_pkg.sv
package retreg_pkg;

    // one bit per monitored sequence error
    typedef struct packed {
        logic save;
        logic restore;
        logic lost;
    } viol_t;

    // previous samples of the slow control inputs
    typedef struct packed {
        logic rclk;
        logic keep;
        logic prim;
    } smp_t;

endpackage

// File: rtl/retreg_sampler.sv
module retreg_sampler
    import retreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rclk_i,
    input  logic keep_i,
    input  logic prim_i,
    output logic rclk_rise_o,
    output logic keep_fall_o,
    output logic prim_fall_o,
    output logic keep_prev_o
);

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d      = smp_q;
        smp_d.rclk = rclk_i;
        smp_d.keep = keep_i;
        smp_d.prim = prim_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end

    assign rclk_rise_o = rclk_i & ~smp_q.rclk;
    assign keep_fall_o = ~keep_i & smp_q.keep;
    assign prim_fall_o = ~prim_i & smp_q.prim;
    assign keep_prev_o = smp_q.keep;

endmodule

// File: rtl/retreg_store.sv
module retreg_store #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din_i,
    input  logic             rclk_i,
    input  logic             rclk_rise_i,
    input  logic             keep_i,
    input  logic             keep_fall_i,
    input  logic             prim_i,
    input  logic             bkup_i,
    output logic [WIDTH-1:0] main_o,
    output logic             main_ok_o
);

    typedef struct packed {
        logic [WIDTH-1:0] main;
        logic [WIDTH-1:0] shadow;
        logic             main_ok;
        logic             sh_ok;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // primary domain
        if (!prim_i) begin
            st_d.main_ok = 1'b0;
        end else if (keep_fall_i) begin
            st_d.main    = st_q.shadow;
            st_d.main_ok = st_q.sh_ok & ~rclk_i;
        end else if (keep_i && rclk_rise_i) begin
            st_d.main    = din_i;
            st_d.main_ok = 1'b1;
        end
        // always-on domain: follows the next main value while saving
        if (!bkup_i) begin
            st_d.sh_ok = 1'b0;
        end else if (keep_i && prim_i && st_d.main_ok) begin
            st_d.shadow = st_d.main;
            st_d.sh_ok  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign main_o    = st_q.main;
    assign main_ok_o = st_q.main_ok;

    // R1: a sampled capture edge lands the data word
    a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (prim_i && keep_i && rclk_rise_i) |=> (main_ok_o && main_o == $past(din_i)));

    // R2: with control low and no restore edge, the stored word stays put
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (prim_i && !keep_i && !keep_fall_i) |=> ($stable(main_o) && $stable(main_ok_o)));

    // R4: restore with register clock high never yields a valid word
    a_r4_bad_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (keep_fall_i && rclk_i) |=> !main_ok_o);

    // R7: backup loss discards the retained copy
    a_r7_backup_gone: assert property (@(posedge clk) disable iff (!rst_n)
        (!bkup_i) |=> !st_q.sh_ok);

    // R8: primary off always leaves the main copy invalid
    a_r8_no_value_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
        (!prim_i) |=> !main_ok_o);

endmodule

// File: rtl/retreg_monitor.sv
module retreg_monitor
    import retreg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  viol_t            evt_i,
    input  logic             clr_i,
    output viol_t            flags_o,
    output logic [CNT_W-1:0] stamp_o
);

    typedef struct packed {
        viol_t            flags;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] stamp;
    } mon_t;

    mon_t m_d, m_q;
    logic armed;

    always_comb begin
        m_d       = m_q;
        armed     = (m_q.flags == '0) || clr_i;
        m_d.cnt   = m_q.cnt + 1'b1;
        m_d.flags = (clr_i ? viol_t'('0) : m_q.flags) | evt_i;
        if (armed && (evt_i != '0))
            m_d.stamp = m_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign flags_o = m_q.flags;
    assign stamp_o = m_q.stamp;

    // R9: flags stay set without a clear
    a_r9_sticky_save: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o.save && !clr_i) |=> flags_o.save);
    a_r9_sticky_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o.restore && !clr_i) |=> flags_o.restore);
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && evt_i == '0) |=> (flags_o == '0));

    // R10: the stamp is frozen once an error is recorded
    a_r10_stamp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o != '0 && !clr_i) |=> $stable(stamp_o));

endmodule

// File: rtl/retention_reg.sv
module retention_reg
    import retreg_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rclk_i,
    input  logic [WIDTH-1:0] din_i,
    input  logic             keep_i,
    input  logic             prim_ok_i,
    input  logic             bkup_ok_i,
    input  logic             gnd_ok_i,
    input  logic             clr_i,
    output logic [WIDTH-1:0] dout_o,
    output logic             dout_valid_o,
    output logic             err_save_o,
    output logic             err_restore_o,
    output logic             err_lost_o,
    output logic [CNT_W-1:0] stamp_o
);

    logic             rclk_rise, keep_fall_raw, keep_fall, prim_fall, keep_prev;
    logic [WIDTH-1:0] main_w;
    logic             main_ok;
    viol_t            evt, flags;

    retreg_sampler u_smp (
        .clk         (clk),
        .rst_n       (rst_n),
        .rclk_i      (rclk_i),
        .keep_i      (keep_i),
        .prim_i      (prim_ok_i),
        .rclk_rise_o (rclk_rise),
        .keep_fall_o (keep_fall_raw),
        .prim_fall_o (prim_fall),
        .keep_prev_o (keep_prev)
    );

    // the control input lives on the backup domain
    assign keep_fall = keep_fall_raw & bkup_ok_i;

    retreg_store #(.WIDTH(WIDTH)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .din_i       (din_i),
        .rclk_i      (rclk_i),
        .rclk_rise_i (rclk_rise),
        .keep_i      (keep_i),
        .keep_fall_i (keep_fall),
        .prim_i      (prim_ok_i),
        .bkup_i      (bkup_ok_i),
        .main_o      (main_w),
        .main_ok_o   (main_ok)
    );

    always_comb begin
        evt         = '0;
        evt.save    = prim_fall & keep_prev;
        evt.restore = keep_fall & rclk_i;
        evt.lost    = ~bkup_ok_i & ~prim_ok_i;
    end

    retreg_monitor #(.CNT_W(CNT_W)) u_mon (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt),
        .clr_i   (clr_i),
        .flags_o (flags),
        .stamp_o (stamp_o)
    );

    assign dout_valid_o  = prim_ok_i & bkup_ok_i & gnd_ok_i & main_ok;
    assign dout_o        = dout_valid_o ? main_w : {WIDTH{1'bx}};
    assign err_save_o    = flags.save;
    assign err_restore_o = flags.restore;
    assign err_lost_o    = flags.lost;

    // R6: an unsafe power-down is recorded at the next edge
    a_r6_save_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (prim_fall && keep_prev) |=> err_save_o);

    // R7: backup loss during power-down is recorded at the next edge
    a_r7_lost_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!bkup_ok_i && !prim_ok_i) |=> err_lost_o);

endmodule

// File: tb/sim_retention_reg.sv
`timescale 1ns/1ps
module sim_retention_reg;

    localparam int W = 4;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n, rclk, keep, prim, bkup, gnd, clr;
    logic [W-1:0]  din;
    logic [W-1:0]  dout;
    logic          dvalid, e_save, e_rest, e_lost;
    logic [CW-1:0] stamp;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit done = 1'b0;
    int s_first;

    always #10 clk = ~clk;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    retention_reg #(.WIDTH(W), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .rclk_i(rclk), .din_i(din), .keep_i(keep),
        .prim_ok_i(prim), .bkup_ok_i(bkup), .gnd_ok_i(gnd), .clr_i(clr),
        .dout_o(dout), .dout_valid_o(dvalid), .err_save_o(e_save),
        .err_restore_o(e_rest), .err_lost_o(e_lost), .stamp_o(stamp)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // fields: rclk keep prim bkup gnd | din | exp_valid | exp_data
    localparam logic [13:0] TBL [19] = '{
        14'b0_1_1_1_1_0101_0_0000, // R8 power-up, nothing held
        14'b1_1_1_1_1_0101_1_0101, // R1 capture
        14'b0_1_1_1_1_1001_1_0101,
        14'b1_1_1_1_1_1001_1_1001, // R1 capture
        14'b0_1_1_1_1_0011_1_1001,
        14'b0_0_1_1_1_0011_1_1001, // R3 legal restore
        14'b1_0_1_1_1_0011_1_1001, // R2 edge ignored
        14'b0_0_0_1_1_0011_0_0000, // R5 primary off
        14'b0_0_0_1_1_0011_0_0000,
        14'b0_0_1_1_1_0011_0_0000, // R8 back on, empty
        14'b0_1_1_1_1_0011_0_0000,
        14'b0_0_1_1_1_0011_1_1001, // R3 restored after power cycle
        14'b0_1_1_1_1_0110_1_1001,
        14'b1_1_1_1_1_0110_1_0110, // R1
        14'b1_1_1_1_0_0110_0_0000, // R5 ground fault
        14'b0_1_1_1_1_0110_1_0110,
        14'b0_1_1_0_1_0110_0_0000, // R5 backup off
        14'b0_1_1_1_1_0110_1_0110, // R3 backup copy re-follows
        14'b0_0_1_1_1_0110_1_0110  // R3 restore
    };

    initial begin
        rst_n = 1'b0; rclk = 1'b0; keep = 1'b0; prim = 1'b0;
        bkup = 1'b1; gnd = 1'b1; clr = 1'b0; din = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        chk("R11 valid", {31'd0, dvalid}, 32'd0);
        chk("R11 flags", {29'd0, e_save, e_rest, e_lost}, 32'd0);
        chk("R11 stamp", {16'd0, stamp}, 32'd0);

        for (int i = 0; i < 19; i++) begin
            {rclk, keep, prim, bkup, gnd, din} = TBL[i][13:5];
            step();
            chk($sformatf("R1/R3/R5 row %0d valid", i), {31'd0, dvalid}, {31'd0, TBL[i][4]});
            if (TBL[i][4])
                chk($sformatf("R1/R3 row %0d data", i), {28'd0, dout}, {28'd0, TBL[i][3:0]});
            chk($sformatf("R9 row %0d no flags", i), {29'd0, e_save, e_rest, e_lost}, 32'd0);
        end

        // R4 restore with register clock high
        keep = 1'b1; rclk = 1'b1; din = 4'hA; step();
        chk("R1 capture A", {28'd0, dout}, 32'hA);
        keep = 1'b0; step();
        chk("R4 restore flag", {31'd0, e_rest}, 32'd1);
        chk("R4 output invalid", {31'd0, dvalid}, 32'd0);
        chk("R10 first stamp", {16'd0, stamp}, cyc - 1);
        rclk = 1'b0; step();
        chk("R9 sticky", {31'd0, e_rest}, 32'd1);
        clr = 1'b1; step(); clr = 1'b0;
        chk("R9 clear", {29'd0, e_save, e_rest, e_lost}, 32'd0);

        // R6 unsafe power-down
        keep = 1'b1; step();
        rclk = 1'b1; din = 4'h3; step();
        chk("R1 capture 3", {28'd0, dout}, 32'h3);
        rclk = 1'b0; step();
        prim = 1'b0; step();
        chk("R6 save flag", {31'd0, e_save}, 32'd1);
        s_first = cyc - 1;
        chk("R10 stamp on save", {16'd0, stamp}, s_first);
        prim = 1'b1; rclk = 1'b1; step();
        keep = 1'b0; step();
        chk("R4 second error", {31'd0, e_rest}, 32'd1);
        chk("R10 stamp held", {16'd0, stamp}, s_first);
        chk("R9 save still set", {31'd0, e_save}, 32'd1);
        rclk = 1'b0; clr = 1'b1; step(); clr = 1'b0;
        chk("R9 clear again", {29'd0, e_save, e_rest, e_lost}, 32'd0);

        // R7 backup lost during power-down
        keep = 1'b1; step();
        rclk = 1'b1; din = 4'hC; step();
        rclk = 1'b0; step();
        keep = 1'b0; step();
        chk("R3 restore C", {28'd0, dout}, 32'hC);
        prim = 1'b0; step();
        chk("R6 legal power-down", {31'd0, e_save}, 32'd0);
        bkup = 1'b0; step();
        chk("R7 lost flag", {31'd0, e_lost}, 32'd1);
        chk("R10 stamp re-armed", {16'd0, stamp}, cyc - 1);
        bkup = 1'b1; step();
        prim = 1'b1; step();
        keep = 1'b1; step();
        keep = 1'b0; step();
        chk("R7 restore invalid", {31'd0, dvalid}, 32'd0);
        chk("R7 no restore error", {31'd0, e_rest}, 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule